// File: doc/BRIEF.md
# Pruning-Aware Kernel Sub-Array Scheduler

This block sequences one processing element of a bit-serial in-memory convolution engine. The element keeps the bits of one input channel in a single input sub-array. It also keeps several weight sub-arrays, one for each filter slot of that same channel. For every filter slot the scheduler produces row selects that pair each input bit row with each weight bit row. An external datapath performs the AND, the bit-count, the shift and the accumulation, and it follows these selects.

A small per-slot table marks whole weight sub-arrays as removed by kernel pruning. The scheduler moves from one live slot straight to the next live slot. A pruned slot costs no cycle. All live sub-arrays have the same shape, so every live slot gets the same row pattern. The first pair of a slot carries a clear strobe for the accumulator, and the last pair carries a result strobe. A done pulse marks the end of a run.

Top module: `subarray_sched`

## Requirements
- R1: After reset the block is idle: busy, row_valid, acc_clear, result_valid and done are all 0. Every slot of the pruning table reads as live (bit value 0).
- R2: For each live slot, row_valid is high for exactly IN_BITS*W_BITS consecutive cycles. In these cycles in_row counts up from 0 as the outer loop and w_row counts up from 0 as the inner loop, so w_row changes on every cycle.
- R3: A slot gets all of its row pairs before the next slot begins. Live slots are visited in ascending index order.
- R4: A slot whose table bit is 1 (pruned) never appears on filt_idx while row_valid is high. It costs no cycle: the first pair of the next live slot follows the last pair of the previous live slot on the very next cycle, and the first live slot follows start by one cycle.
- R5: acc_clear is high exactly on the first pair (in_row=0, w_row=0) of each live slot. result_valid is high exactly on its last pair (in_row=IN_BITS-1, w_row=W_BITS-1).
- R6: When start is sampled while idle, busy is high from the next cycle until the last pair of the last live slot. done is a one-cycle pulse in the cycle after that last pair.
- R7: If every slot is pruned, done pulses in the cycle after start, and no row_valid or result_valid is produced.
- R8: A table write (tbl_we, tbl_idx selecting the slot, tbl_pruned as the new bit) takes effect only while idle. A write issued while busy is ignored.
- R9: A start pulse while busy is ignored. The running sequence continues unchanged and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Pruning table write enable |
| tbl_idx | input | SLOT_W | Slot index to write |
| tbl_pruned | input | 1 | New table bit, 1 = pruned |
| start | input | 1 | Begin a pass over all slots |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| row_valid | output | 1 | Row selects are meaningful this cycle |
| filt_idx | output | SLOT_W | Current weight sub-array (filter slot) |
| in_row | output | IN_W | Input sub-array row select |
| w_row | output | WB_W | Weight sub-array row select |
| acc_clear | output | 1 | Clear the accumulator, first pair of a slot |
| result_valid | output | 1 | Accumulated result complete, last pair of a slot |

## Verification
The bench aims at slot patterns where pruned slots lie at the edges and in runs between live ones. A design that spent cycles on pruned slots would shift every later pair and push done late. A design that mishandled the lowest or highest slot would drop or repeat a filter. An all-pruned table checks that done comes out without any row activity; a design that still emitted one stray pair would be caught. A start pulse and a table write arrive in the middle of a pass. The bench then checks that neither changes the current pass and that the table still holds its previous contents on the next pass.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sched_state_e;
endpackage

// File: rtl/prune_table.sv
// One flag per filter slot plus a lookahead that finds the lowest live
// slot at or above a given index, so pruned slots cost no cycles.
module prune_table #(
  parameter int N_SLOTS = 8,
  parameter int SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_idx,
  input  logic              wr_val,
  input  logic [SLOT_W:0]   search_lo,
  output logic              found,
  output logic [SLOT_W-1:0] found_idx,
  output logic [N_SLOTS-1:0] pruned_bits
);
  localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(N_SLOTS);

  logic [N_SLOTS-1:0] flags_q;
  logic [N_SLOTS-1:0] cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (wr_en && ({1'b0, wr_idx} < SLOT_LIMIT)) begin
      flags_q[wr_idx] <= wr_val;
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cand
    localparam logic [SLOT_W:0] G_IDX = (SLOT_W+1)'(g);
    assign cand[g] = !flags_q[g] && (G_IDX >= search_lo);
  end

  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found     = 1'b1;
        found_idx = SLOT_W'(i);
      end
    end
  end

  assign pruned_bits = flags_q;

  // the lookahead result must always name a live slot
  AST_FOUND_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
    found |-> !flags_q[found_idx]); // R4
endmodule

// File: rtl/row_walker.sv
// Nested row counter: input row outer, weight row inner, wraps after the
// last pair so back-to-back sub-arrays need no reload cycle.
module row_walker #(
  parameter int IN_BITS = 3,
  parameter int W_BITS  = 3,
  parameter int IN_W    = 2,
  parameter int WB_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            step,
  output logic [IN_W-1:0] in_row,
  output logic [WB_W-1:0] w_row,
  output logic            first,
  output logic            last
);
  localparam logic [IN_W-1:0] IN_MAX = IN_W'(IN_BITS - 1);
  localparam logic [WB_W-1:0] W_MAX  = WB_W'(W_BITS - 1);

  logic [IN_W-1:0] in_q;
  logic [WB_W-1:0] w_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      in_q <= '0;
      w_q  <= '0;
    end else if (step) begin
      if (w_q == W_MAX) begin
        w_q  <= '0;
        in_q <= (in_q == IN_MAX) ? '0 : in_q + 1'b1;
      end else begin
        w_q <= w_q + 1'b1;
      end
    end
  end

  assign in_row = in_q;
  assign w_row  = w_q;
  assign first  = (in_q == '0) && (w_q == '0);
  assign last   = (in_q == IN_MAX) && (w_q == W_MAX);

  AST_ROW_BOUND: assert property (@(posedge clk) disable iff (rst)
    (in_q <= IN_MAX) && (w_q <= W_MAX)); // R2
  AST_INNER_LOOP: assert property (@(posedge clk) disable iff (rst)
    (step && !clear && (w_q != W_MAX)) |=> $stable(in_q)); // R2
endmodule

// File: rtl/subarray_sched.sv
module subarray_sched #(
  parameter int N_SLOTS = 8,
  parameter int IN_BITS = 3,
  parameter int W_BITS  = 3,
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int IN_W   = (IN_BITS > 1) ? $clog2(IN_BITS) : 1,
  localparam int WB_W   = (W_BITS > 1) ? $clog2(W_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_idx,
  input  logic              tbl_pruned,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              row_valid,
  output logic [SLOT_W-1:0] filt_idx,
  output logic [IN_W-1:0]   in_row,
  output logic [WB_W-1:0]   w_row,
  output logic              acc_clear,
  output logic              result_valid
);
  import sched_pkg::*;

  sched_state_e      state_q;
  logic [SLOT_W-1:0] filt_q;
  logic              done_q;
  logic              running;
  logic [SLOT_W:0]   search_lo;
  logic              nxt_found;
  logic [SLOT_W-1:0] nxt_idx;
  logic [N_SLOTS-1:0] pruned_bits;
  logic              pair_first;
  logic              pair_last;

  assign running   = (state_q == ST_RUN);
  assign search_lo = running ? ({1'b0, filt_q} + 1'b1) : '0;

  prune_table #(
    .N_SLOTS (N_SLOTS),
    .SLOT_W  (SLOT_W)
  ) i_table (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (tbl_we && !running),
    .wr_idx      (tbl_idx),
    .wr_val      (tbl_pruned),
    .search_lo   (search_lo),
    .found       (nxt_found),
    .found_idx   (nxt_idx),
    .pruned_bits (pruned_bits)
  );

  row_walker #(
    .IN_BITS (IN_BITS),
    .W_BITS  (W_BITS),
    .IN_W    (IN_W),
    .WB_W    (WB_W)
  ) i_walker (
    .clk    (clk),
    .rst    (rst),
    .clear  (!running),
    .step   (running),
    .in_row (in_row),
    .w_row  (w_row),
    .first  (pair_first),
    .last   (pair_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      filt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (nxt_found) begin
              state_q <= ST_RUN;
              filt_q  <= nxt_idx;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (pair_last) begin
            if (nxt_found) begin
              filt_q <= nxt_idx;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = running;
  assign row_valid    = running;
  assign filt_idx     = filt_q;
  assign done         = done_q;
  assign acc_clear    = running && pair_first;
  assign result_valid = running && pair_last;

  AST_LIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> !pruned_bits[filt_idx]); // R4
  AST_SWITCH_AFTER_RESULT: assert property (@(posedge clk) disable iff (rst)
    (row_valid && $past(row_valid) && (filt_idx != $past(filt_idx))) |-> $past(result_valid)); // R3
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (row_valid && $past(row_valid) && (filt_idx != $past(filt_idx))) |-> (filt_idx > $past(filt_idx))); // R3
  AST_CLEAR_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (row_valid && $past(row_valid) && $past(result_valid)) |-> acc_clear); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (tbl_we && busy) |=> $stable(pruned_bits)); // R8
endmodule

// File: tb/test_subarray_sched.sv
module test_subarray_sched;
  localparam int N_SLOTS = 8;
  localparam int IN_BITS = 3;
  localparam int W_BITS  = 3;
  localparam int SLOT_W  = 3;
  localparam int IN_W    = 2;
  localparam int WB_W    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [SLOT_W-1:0] tbl_idx = '0;
  logic tbl_pruned = 1'b0;
  logic start = 1'b0;
  logic busy, done, row_valid, acc_clear, result_valid;
  logic [SLOT_W-1:0] filt_idx;
  logic [IN_W-1:0] in_row;
  logic [WB_W-1:0] w_row;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  logic [N_SLOTS-1:0] model_mask = '0;

  always #5 clk = ~clk;

  subarray_sched #(
    .N_SLOTS (N_SLOTS),
    .IN_BITS (IN_BITS),
    .W_BITS  (W_BITS)
  ) i_subarray_sched (
    .clk          (clk),
    .rst          (rst),
    .tbl_we       (tbl_we),
    .tbl_idx      (tbl_idx),
    .tbl_pruned   (tbl_pruned),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .row_valid    (row_valid),
    .filt_idx     (filt_idx),
    .in_row       (in_row),
    .w_row        (w_row),
    .acc_clear    (acc_clear),
    .result_valid (result_valid)
  );

  function automatic logic [31:0] pack(int f, int i, int w, bit c, bit r);
    return {8'(f), 8'(i), 8'(w), 6'd0, c, r};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: pops expected pairs as the design emits them
  always @(negedge clk) begin
    if (!rst) begin
      if (row_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 R7 unexpected pair", {8'(filt_idx), 8'(in_row), 8'(w_row), 8'd0}, 32'd0);
        end else begin
          logic [31:0] e;
          logic [31:0] a;
          e = exp_q.pop_front();
          a = pack(int'(filt_idx), int'(in_row), int'(w_row), acc_clear, result_valid);
          chk(a == e, "R2 R3 R4 R5 pair", a, e);
        end
      end else if (acc_clear || result_valid) begin
        chk(1'b0, "R5 strobe outside pair", {30'd0, acc_clear, result_valid}, 32'd0);
      end
    end
  end

  task automatic load_table(logic [N_SLOTS-1:0] mask);
    for (int s = 0; s < N_SLOTS; s++) begin
      @(negedge clk);
      tbl_we = 1'b1;
      tbl_idx = SLOT_W'(s);
      tbl_pruned = mask[s];
    end
    @(negedge clk);
    tbl_we = 1'b0;
    model_mask = mask;
  endtask

  // driver: pushes expected pairs, pulses start, checks busy/done timing
  task automatic run_case(string tag, bit disturb);
    int live;
    int len;
    live = 0;
    for (int f = 0; f < N_SLOTS; f++) begin
      if (!model_mask[f]) begin
        live++;
        for (int i = 0; i < IN_BITS; i++)
          for (int w = 0; w < W_BITS; w++)
            exp_q.push_back(pack(f, i, w, (i == 0) && (w == 0),
                                 (i == IN_BITS - 1) && (w == W_BITS - 1)));
      end
    end
    len = live * IN_BITS * W_BITS;
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k <= len; k++) begin
      @(negedge clk);
      start = 1'b0;
      tbl_we = 1'b0;
      if (k == len) begin
        chk(done == 1'b1, {tag, " R6 R7 done timing"}, 32'(done), 32'd1);
        chk(busy == 1'b0, {tag, " R6 busy low at done"}, 32'(busy), 32'd0);
      end else begin
        chk(done == 1'b0 && busy == 1'b1, {tag, " R6 busy during pass"},
            {30'd0, busy, done}, 32'd2);
      end
      if (disturb && k == 2) begin
        start = 1'b1;      // R9 ignored while busy
        tbl_we = 1'b1;     // R8 ignored while busy
        tbl_idx = SLOT_W'(N_SLOTS - 1);
        tbl_pruned = 1'b1;
      end
    end
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, {tag, " R6 R9 no further run"},
          {30'd0, busy, done}, 32'd0);
    end
    chk(exp_q.size() == 0, {tag, " R2 all pairs seen"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, row_valid, done, acc_clear, result_valid} == 5'b0, "R1 reset outputs",
        {27'd0, busy, row_valid, done, acc_clear, result_valid}, 32'd0);
    run_case("R1 table live after reset", 1'b0);
    load_table(8'b1010_0110);
    run_case("R4 mixed pruning", 1'b0);
    load_table(8'b1111_1111);
    run_case("R7 all pruned", 1'b0);
    load_table(8'b0111_1111);
    run_case("R4 only top slot", 1'b0);
    load_table(8'b1111_1110);
    run_case("R4 only slot zero", 1'b0);
    load_table(8'b0001_1000);
    run_case("R8 R9 disturbed pass", 1'b1);
    run_case("R8 table unchanged", 1'b0);
    load_table(8'b0000_0000);
    run_case("R3 all live ascending", 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule